// File: doc/BRIEF.md
# Rectifier Drive Skew Unit

This unit sits behind the PWM engine of a phase-shifted full-bridge controller. From the two lower-switch PWM signals it makes the two synchronous-rectifier gate signals. Each rectifier gate is the inverse of the PWM signal on the opposite side. A single signed skew setting then moves one group of signals later in time than the other. This compensates for unequal propagation delays, for example when one group crosses an isolation barrier.

A negative skew code delays the PWM pair, and the two 50% upper-switch signals are delayed by the same number of cycles, so the resonant timing between upper and lower switches is preserved. A positive code delays the rectifier pair instead. Small codes near zero fall inside a dead band and give no delay. Delays are counted in clock cycles and are clamped to the count that matches the ±300 ns skew range (37 cycles at 125 MHz).

A new skew code is sampled only when the upper-left signal changes level, which marks an oscillator half-period boundary, so no pulse is cut short. An active fault forces every output low.

Top module: `sr_skew`

## Requirements
- R1: With zero effective delay and no fault, `sr_o[0]` equals the inverse of `pwm_o[1]` and `sr_o[1]` equals the inverse of `pwm_o[0]`. With `pwm_i` = 2'b01 this gives `sr_o` = 2'b01, and with `pwm_i` = 2'b10 it gives `sr_o` = 2'b10.
- R2: While both PWM inputs are low (zero duty) and no fault is present, both rectifier outputs are high.
- R3: A skew code whose magnitude is at most DEAD_BAND (1) produces zero delay on every output. Code 2 is outside the band and gives a delay of 2.
- R4: A negative code delays `pwm_o` and `up_o` by min(|code|, MAX_DLY) cycles, and leaves the rectifier outputs undelayed.
- R5: A positive code delays `sr_o` by min(code, MAX_DLY) cycles, and leaves `pwm_o` and `up_o` undelayed.
- R6: The delay never exceeds MAX_DLY (37). Codes 63 and -64 both give exactly 37.
- R7: The code on `skew_i` is captured only on a clock edge where `up_i[0]` differs from its value at the previous edge. It governs the delays from the next cycle onward. A code change with no such boundary has no effect on the outputs.
- R8: While `fault_i` is high, `pwm_o`, `sr_o` and `up_o` are all zero in the same cycle.
- R9: After reset the effective delay is zero and the delay history is cleared. With all inputs low, `pwm_o` = 0, `sr_o` = 2'b11 and `up_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_i | input | 2 | Lower PWM signals: bit 0 lower-left, bit 1 lower-right |
| up_i | input | 2 | 50% upper-switch signals: bit 0 upper-left, bit 1 upper-right |
| skew_i | input | 7 | Signed skew code; negative delays the PWM side, positive delays the rectifier side |
| fault_i | input | 1 | Fault; forces all outputs low |
| pwm_o | output | 2 | Possibly delayed lower PWM pair |
| sr_o | output | 2 | Rectifier gates: bit 0 pairs with lower-left PWM, bit 1 with lower-right |
| up_o | output | 2 | Upper pair, delayed by the same amount as the PWM pair |

## Verification
The undelayed path is combinational, so a result with zero delay is due in the same cycle as its input. A result with delay d appears d clock edges after the input edge. The bench drives each input just after a falling edge and samples shortly after that point, then after every later falling edge. For each output it records the index of the first sample showing the change and compares that index with the expected delay. A code change becomes active one edge after the upper-left level change that captures it, so the bench flushes the delay line for more than MAX_DLY cycles before it measures anything.

// File: rtl/sr_skew_pkg.sv
package sr_skew_pkg;

    localparam int DEF_CODE_W    = 7;
    localparam int DEF_MAX_DLY   = 37;   // 300 ns at 8 ns per cycle
    localparam int DEF_DEAD_BAND = 1;

    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_PWM  = 2'd1,
        SIDE_SR   = 2'd2
    } skew_side_e;

    typedef struct packed {
        logic [1:0] up;
        logic [1:0] lo;
    } primary_t;

endpackage

// File: rtl/skew_decode.sv
module skew_decode
    import sr_skew_pkg::*;
#(
    parameter int CODE_W    = DEF_CODE_W,
    parameter int MAX_DLY   = DEF_MAX_DLY,
    parameter int DEAD_BAND = DEF_DEAD_BAND,
    localparam int DLY_W    = $clog2(MAX_DLY + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     up_ref,
    input  logic signed [CODE_W-1:0] code_i,
    output logic [DLY_W-1:0]         pwm_dly,
    output logic [DLY_W-1:0]         sr_dly
);
    logic signed [CODE_W-1:0] act_q;
    logic                     up_q;
    logic                     boundary;
    logic signed [CODE_W:0]   ext;
    logic [CODE_W:0]          mag;
    logic [DLY_W-1:0]         cnt;
    skew_side_e               side;

    assign boundary = up_ref ^ up_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            up_q  <= 1'b0;
        end else begin
            up_q <= up_ref;
            if (boundary)
                act_q <= code_i;
        end
    end

    always_comb begin
        ext = {act_q[CODE_W-1], act_q};
        mag = (ext < 0) ? $unsigned(-ext) : $unsigned(ext);
        if (mag <= (CODE_W+1)'(DEAD_BAND))
            cnt = '0;
        else if (mag > (CODE_W+1)'(MAX_DLY))
            cnt = DLY_W'(MAX_DLY);
        else
            cnt = DLY_W'(mag);
        if (cnt == '0)
            side = SIDE_NONE;
        else if (act_q[CODE_W-1])
            side = SIDE_PWM;
        else
            side = SIDE_SR;
        pwm_dly = (side == SIDE_PWM) ? cnt : '0;
        sr_dly  = (side == SIDE_SR)  ? cnt : '0;
    end

    assert_one_side_R4: assert property (@(posedge clk) disable iff (rst)
        !(pwm_dly != '0 && sr_dly != '0));

    assert_clamp_R6: assert property (@(posedge clk) disable iff (rst)
        (pwm_dly <= DLY_W'(MAX_DLY)) && (sr_dly <= DLY_W'(MAX_DLY)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(act_q));

endmodule

// File: rtl/tap_delay.sv
module tap_delay #(
    parameter int W     = 2,
    parameter int DEPTH = 37,
    localparam int SEL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     d,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     q
);
    logic [W-1:0] hist [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) hist[0] <= '0;
        else     hist[0] <= d;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) hist[i] <= '0;
            else     hist[i] <= hist[i-1];
        end
    end

    always_comb begin
        if (sel == '0)
            q = d;
        else if (sel > SEL_W'(DEPTH))
            q = hist[DEPTH-1];
        else
            q = hist[sel - SEL_W'(1)];
    end

endmodule

// File: rtl/sr_skew.sv
module sr_skew
    import sr_skew_pkg::*;
#(
    parameter int CODE_W    = DEF_CODE_W,
    parameter int MAX_DLY   = DEF_MAX_DLY,
    parameter int DEAD_BAND = DEF_DEAD_BAND
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        pwm_i,
    input  logic [1:0]        up_i,
    input  logic [CODE_W-1:0] skew_i,
    input  logic              fault_i,
    output logic [1:0]        pwm_o,
    output logic [1:0]        sr_o,
    output logic [1:0]        up_o
);
    localparam int DLY_W = $clog2(MAX_DLY + 1);

    logic [DLY_W-1:0] pwm_dly;
    logic [DLY_W-1:0] sr_dly;
    primary_t         prim_in;
    primary_t         prim_tap;
    logic [1:0]       sr_tap;

    skew_decode #(
        .CODE_W   (CODE_W),
        .MAX_DLY  (MAX_DLY),
        .DEAD_BAND(DEAD_BAND)
    ) u_decode (
        .clk    (clk),
        .rst    (rst),
        .up_ref (up_i[0]),
        .code_i ($signed(skew_i)),
        .pwm_dly(pwm_dly),
        .sr_dly (sr_dly)
    );

    assign prim_in.up = up_i;
    assign prim_in.lo = pwm_i;

    // primary side: lower PWM and upper 50% signals share one delay
    tap_delay #(.W(4), .DEPTH(MAX_DLY)) u_prim_line (
        .clk(clk),
        .rst(rst),
        .d  (prim_in),
        .sel(pwm_dly),
        .q  (prim_tap)
    );

    // rectifier side: PWM history, inverted and cross-paired at the output
    tap_delay #(.W(2), .DEPTH(MAX_DLY)) u_sr_line (
        .clk(clk),
        .rst(rst),
        .d  (pwm_i),
        .sel(sr_dly),
        .q  (sr_tap)
    );

    always_comb begin
        if (fault_i) begin
            pwm_o = '0;
            up_o  = '0;
            sr_o  = '0;
        end else begin
            pwm_o = prim_tap.lo;
            up_o  = prim_tap.up;
            sr_o  = ~{sr_tap[0], sr_tap[1]};
        end
    end

    assert_fault_low_R8: assert property (@(posedge clk) disable iff (rst)
        fault_i |-> (pwm_o == 2'b00 && sr_o == 2'b00 && up_o == 2'b00));

    assert_cross_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (!fault_i && pwm_dly == '0 && sr_dly == '0)
            |-> (sr_o[0] == !pwm_o[1] && sr_o[1] == !pwm_o[0]));

endmodule

// File: tb/sr_skew_tb.sv
`timescale 1ns/1ps
module sr_skew_tb;
    localparam int MAX = 37;
    localparam int NV  = 11;
    // code, expected PWM/upper delay, expected rectifier delay
    localparam int VEC [NV][3] = '{
        '{0, 0, 0}, '{1, 0, 0}, '{-1, 0, 0}, '{2, 0, 2}, '{-2, 2, 0},
        '{5, 0, 5}, '{-10, 10, 0}, '{37, 0, 37}, '{-37, 37, 0},
        '{63, 0, 37}, '{-64, 37, 0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] pwm_i = 2'b00;
    logic [1:0] up_i = 2'b00;
    logic [6:0] skew_i = '0;
    logic       fault_i = 1'b0;
    logic [1:0] pwm_o, sr_o, up_o;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sr_skew u_dut (
        .clk(clk), .rst(rst), .pwm_i(pwm_i), .up_i(up_i), .skew_i(skew_i),
        .fault_i(fault_i), .pwm_o(pwm_o), .sr_o(sr_o), .up_o(up_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(input bit do_up, output int kp, output int ks, output int ku);
        logic up_last;
        kp = -1; ks = -1; ku = -1;
        @(negedge clk);
        up_last = up_o[0];
        pwm_i[0] = 1'b1;
        if (do_up) up_i = ~up_i;
        for (int k = 0; k <= MAX + 4; k++) begin
            if (k > 0) @(negedge clk);
            #1;
            if (kp < 0 && pwm_o[0]) kp = k;
            if (ks < 0 && !sr_o[1]) ks = k;
            if (do_up && ku < 0 && up_o[0] != up_last) ku = k;
        end
        pwm_i[0] = 1'b0;
        repeat (MAX + 4) @(negedge clk);
    endtask

    task automatic latch_code(input int code);
        @(negedge clk);
        skew_i = 7'(code);
        @(negedge clk);
        up_i = ~up_i;
        repeat (MAX + 4) @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int kp, ks, ku;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R9 pwm_o after reset", pwm_o, 0);
        check("R9 sr_o after reset", sr_o, 3);
        check("R9 up_o after reset", up_o, 0);

        for (int v = 0; v < NV; v++) begin
            latch_code(VEC[v][0]);
            measure(1'b1, kp, ks, ku);
            // R3 dead band, R4 PWM side, R5 rectifier side, R6 clamp
            check($sformatf("R3/R4/R6 pwm delay code %0d", VEC[v][0]), kp, VEC[v][1]);
            check($sformatf("R3/R5/R6 sr delay code %0d", VEC[v][0]), ks, VEC[v][2]);
            check($sformatf("R4 upper delay code %0d", VEC[v][0]), ku, VEC[v][1]);
        end

        // R7: new code without a boundary must not apply
        @(negedge clk);
        skew_i = 7'd3;
        repeat (MAX + 4) @(negedge clk);
        measure(1'b0, kp, ks, ku);
        check("R7 pwm delay held", kp, 37);
        check("R7 sr delay held", ks, 0);
        @(negedge clk);
        up_i = ~up_i;
        repeat (MAX + 4) @(negedge clk);
        measure(1'b0, kp, ks, ku);
        check("R7 pwm delay after boundary", kp, 0);
        check("R7 sr delay after boundary", ks, 3);

        latch_code(0);
        @(negedge clk); pwm_i = 2'b01; #1;
        check("R1 sr_o with lower-left on", sr_o, 2'b01);
        @(negedge clk); pwm_i = 2'b10; #1;
        check("R1 sr_o with lower-right on", sr_o, 2'b10);
        @(negedge clk); pwm_i = 2'b00; #1;
        check("R2 sr_o at zero duty", sr_o, 2'b11);
        @(negedge clk); pwm_i = 2'b01; up_i = 2'b11; fault_i = 1'b1; #1;
        check("R8 pwm_o under fault", pwm_o, 0);
        check("R8 sr_o under fault", sr_o, 0);
        check("R8 up_o under fault", up_o, 0);
        @(negedge clk); fault_i = 1'b0; #1;
        check("R1 sr_o after fault clears", sr_o, 2'b01);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule